// File: doc/BRIEF.md
# Serial Boot Mode Loader

This block brings a processor's fundamental operating modes in from a slow serial stream at power-up. Once the power-good input goes high, it waits a fixed number of master clock cycles, then produces a divided mode clock. On each mode clock period it samples one bit of a configuration stream, taking the lowest-numbered bit first. When the last bit has been taken, it decodes the low field bits into registered mode outputs and raises a done flag. After that, it counts out a long cold-reset hold window before it allows the processor to leave reset.

The decoded outputs are these:

- the PLL multiplier code and the factor it selects
- byte order and external bus width
- non-block write mode and block write data pattern
- write address-to-data delay
- output drive strength, both as a code and as a percentage
- a timer-interrupt disable

An error flag reports a reserved multiplier code, a reserved data pattern code, or a nonzero value in the stream position that must be zero.

A warm reset only withholds the release output. The stream is not loaded again, and the latched modes are kept. Dropping power-good clears everything, and the next rise of power-good starts a fresh load.

Top module: `boot_mode_loader`

## Requirements
- R1: While `rst_n` is low, and while `pwr_good` stays low after reset, `mode_clk`, `cfg_done`, `cfg_err`, `cpu_release` and all mode fields are 0.
- R2: The first rising edge of `mode_clk` comes START_DELAY + DIV_RATIO/2 master clock edges after the first edge that samples `pwr_good` high.
- R3: `mode_clk` has a period of DIV_RATIO master clocks. It is low in the first half and high in the second half. It shows exactly STREAM_BITS rising edges per load and is low at all other times. Each stream bit is sampled at the master edge where `mode_clk` falls.
- R4: Stream bit k is the (k+1)-th sample, so bit 0 is the first bit shifted in and bit STREAM_BITS-1 is the last.
- R5: The fields are decoded from these stream positions:
  - multiplier code: bits 7:5
  - byte order: bit 8 (1 = big endian)
  - non-block write mode: bits 10:9
  - timer interrupt disable: bit 11
  - bus width: bit 12 (1 = 32-bit)
  - drive strength code: bits 14:13
  - block write data pattern: bits 4:1
  - write delay: bits 17:15
- R6: `mult_factor` is the multiplier code plus 2 for codes 0 to 6. For the reserved code 7 it is 0.
- R7: `drive_pct` is derived from the drive code: 2'b10 gives 100, 2'b11 gives 83, 2'b00 gives 67 and 2'b01 gives 50.
- R8: `cfg_err` is 1 after a load when at least one of these holds: bit 0 is 1, the multiplier code is 7, or the data pattern code is above 8. Otherwise it is 0.
- R9: Stream bits 255:18 have no effect on any field or on `cfg_err`.
- R10: `cfg_done` rises at the sample edge of the last bit. While `cfg_done` and `pwr_good` are high, every field stays unchanged.
- R11: `cpu_release` rises exactly HOLD_CYCLES master clocks after `cfg_done` rises.
- R12: While `warm_rst` is high, `cpu_release` is low from the next edge onward. It returns one edge after `warm_rst` falls. No reload takes place: fields and `cfg_done` are kept and `mode_clk` stays low.
- R13: When `pwr_good` is sampled low, `cfg_done`, `cfg_err`, `cpu_release`, `mode_clk` and the fields clear at that edge. A later rise of `pwr_good` performs a complete new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_good | input | 1 | Supply-good indication; its rise starts a load |
| warm_rst | input | 1 | Warm reset request; holds release low, no reload |
| serial_in | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided clock for the serial source |
| cfg_done | output | 1 | Stream fully loaded and fields latched |
| cfg_err | output | 1 | Reserved code or must-be-zero violation seen |
| cpu_release | output | 1 | Processor may leave reset |
| mult_code | output | 3 | PLL multiplier code |
| mult_factor | output | 4 | Decoded multiplication factor, 0 if reserved |
| big_endian | output | 1 | Byte order, 1 = big endian |
| bus_32bit | output | 1 | 1 = 32-bit external bus |
| single_wr_mode | output | 2 | Non-block write mode |
| blk_wr_rate | output | 4 | Block write data pattern code |
| wr_data_delay | output | 3 | Write address-to-data delay in master clocks |
| drive_code | output | 2 | Output drive strength code |
| drive_pct | output | 7 | Drive strength in percent |
| timer_irq_off | output | 1 | 1 = timer interrupt disabled |

## Verification
The checker assumes the serial source holds `serial_in` steady for at least the three master clocks that end at each falling `mode_clk` edge. It takes no hold time beyond that edge. The bench meets this by changing the data one nanosecond after each rising `mode_clk` edge, which leaves DIV_RATIO/2 master clocks of settling before the sample. The checker also assumes that `warm_rst` is used only after `cfg_done` has risen and that `pwr_good` is a level input. The bench raises `pwr_good` only from a cleared state and pulses `warm_rst` only once a load has been released.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

   // Stream positions decoded by the loader; everything above is ignored.
   localparam int unsigned FIELD_W       = 18;
   localparam int unsigned POS_ZERO      = 0;
   localparam int unsigned POS_RATE      = 1;
   localparam int unsigned POS_MULT      = 5;
   localparam int unsigned POS_ENDIAN    = 8;
   localparam int unsigned POS_WRMODE    = 9;
   localparam int unsigned POS_TIMER     = 11;
   localparam int unsigned POS_BUSW      = 12;
   localparam int unsigned POS_DRIVE     = 13;
   localparam int unsigned POS_DELAY     = 15;

   localparam logic [2:0] MULT_RSV_CODE = 3'd7;
   localparam logic [3:0] RATE_MAX_CODE = 4'd8;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_WAIT,
      SEQ_SHIFT,
      SEQ_HOLD,
      SEQ_READY
   } seq_state_e;

   typedef struct packed {
      logic [2:0] mult_code;
      logic [3:0] mult_factor;
      logic       big_endian;
      logic       bus_32bit;
      logic [1:0] single_wr_mode;
      logic [3:0] blk_wr_rate;
      logic [2:0] wr_data_delay;
      logic [1:0] drive_code;
      logic [6:0] drive_pct;
      logic       timer_irq_off;
   } boot_cfg_t;

   function automatic logic [3:0] mult_factor_of(input logic [2:0] code);
      return (code == MULT_RSV_CODE) ? 4'd0 : ({1'b0, code} + 4'd2);
   endfunction

   function automatic logic [6:0] drive_pct_of(input logic [1:0] code);
      case (code)
         2'b10:   return 7'd100;
         2'b11:   return 7'd83;
         2'b00:   return 7'd67;
         default: return 7'd50;
      endcase
   endfunction

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
   import boot_cfg_pkg::*;
#(
   parameter int unsigned DIV_RATIO   = 256,
   parameter int unsigned START_DELAY = 256,
   parameter int unsigned STREAM_BITS = 256,
   parameter int unsigned HOLD_CYCLES = 65537
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic warm_rst,
   output logic mode_clk,
   output logic sample_stb,
   output logic last_stb,
   output logic capture_clr,
   output logic cpu_release
);

   localparam int unsigned PH_W    = $clog2(DIV_RATIO);
   localparam int unsigned CNT_MAX = (START_DELAY > HOLD_CYCLES) ? START_DELAY : HOLD_CYCLES;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX) + 1;
   localparam int unsigned IDX_W   = $clog2(STREAM_BITS) + 1;

   localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(DIV_RATIO - 1);
   localparam logic [PH_W-1:0]  PH_MID     = PH_W'(DIV_RATIO / 2 - 1);
   localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_DELAY - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYCLES - 1);
   localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(STREAM_BITS - 1);

   seq_state_e       state_q, state_d;
   logic [PH_W-1:0]  ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             mclk_q, mclk_d;
   logic             rel_q, rel_d;

   assign sample_stb  = (state_q == SEQ_SHIFT) && (ph_q == PH_LAST);
   assign last_stb    = sample_stb && (idx_q == IDX_LAST);
   assign capture_clr = (state_q == SEQ_WAIT) || !pwr_good;

   always_comb begin
      state_d = state_q;
      ph_d    = ph_q;
      cnt_d   = cnt_q;
      idx_d   = idx_q;
      mclk_d  = 1'b0;
      case (state_q)
         SEQ_IDLE: begin
            state_d = SEQ_WAIT;
            cnt_d   = '0;
         end
         SEQ_WAIT: begin
            if (cnt_q == START_LAST) begin
               state_d = SEQ_SHIFT;
               ph_d    = '0;
               idx_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         SEQ_SHIFT: begin
            mclk_d = mclk_q;
            ph_d   = ph_q + 1'b1;
            if (ph_q == PH_MID) begin
               mclk_d = 1'b1;
            end
            if (sample_stb) begin
               ph_d   = '0;
               mclk_d = 1'b0;
               if (last_stb) begin
                  state_d = SEQ_HOLD;
                  cnt_d   = '0;
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         SEQ_HOLD: begin
            if (cnt_q == HOLD_LAST) begin
               state_d = SEQ_READY;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         SEQ_READY: begin
            state_d = SEQ_READY;
         end
         default: begin
            state_d = SEQ_IDLE;
         end
      endcase
      rel_d = (state_d == SEQ_READY) && !warm_rst;
      if (!pwr_good) begin
         state_d = SEQ_IDLE;
         ph_d    = '0;
         cnt_d   = '0;
         idx_d   = '0;
         mclk_d  = 1'b0;
         rel_d   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ph_q    <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         mclk_q  <= 1'b0;
         rel_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ph_q    <= ph_d;
         cnt_q   <= cnt_d;
         idx_q   <= idx_d;
         mclk_q  <= mclk_d;
         rel_q   <= rel_d;
      end
   end

   assign mode_clk    = mclk_q;
   assign cpu_release = rel_q;

endmodule

// File: rtl/boot_capture.sv
module boot_capture
   import boot_cfg_pkg::*;
#(
   parameter int unsigned STREAM_BITS = 256,
   parameter bit          FULL_IMAGE  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               stb,
   input  logic               din,
   output logic [FIELD_W-1:0] img_next
);

   generate
      if (FULL_IMAGE) begin : g_full
         // Whole stream shifts through; the first bit ends at position 0.
         logic [STREAM_BITS-1:0] sh_q, sh_d;

         always_comb begin
            sh_d = stb ? {din, sh_q[STREAM_BITS-1:1]} : sh_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else if (clr) begin
               sh_q <= '0;
            end else begin
               sh_q <= sh_d;
            end
         end

         assign img_next = sh_d[FIELD_W-1:0];
      end else begin : g_idx
         // Only the decoded positions are stored; a saturating pointer steers bits.
         localparam int unsigned PTR_W = $clog2(FIELD_W + 1);
         localparam logic [PTR_W-1:0] PTR_END = PTR_W'(FIELD_W);

         logic [PTR_W-1:0]   ptr_q;
         logic [FIELD_W-1:0] f_q, f_d;

         always_comb begin
            f_d = f_q;
            for (int i = 0; i < FIELD_W; i++) begin
               if (stb && (ptr_q == PTR_W'(i))) begin
                  f_d[i] = din;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q   <= '0;
               ptr_q <= '0;
            end else if (clr) begin
               f_q   <= '0;
               ptr_q <= '0;
            end else begin
               f_q <= f_d;
               if (stb && (ptr_q != PTR_END)) begin
                  ptr_q <= ptr_q + 1'b1;
               end
            end
         end

         assign img_next = f_d;
      end
   endgenerate

endmodule

// File: rtl/boot_field_decode.sv
module boot_field_decode
   import boot_cfg_pkg::*;
(
   input  logic [FIELD_W-1:0] img,
   output boot_cfg_t          cfg,
   output logic               bad
);

   always_comb begin
      cfg.mult_code      = img[POS_MULT +: 3];
      cfg.mult_factor    = mult_factor_of(img[POS_MULT +: 3]);
      cfg.big_endian     = img[POS_ENDIAN];
      cfg.bus_32bit      = img[POS_BUSW];
      cfg.single_wr_mode = img[POS_WRMODE +: 2];
      cfg.blk_wr_rate    = img[POS_RATE +: 4];
      cfg.wr_data_delay  = img[POS_DELAY +: 3];
      cfg.drive_code     = img[POS_DRIVE +: 2];
      cfg.drive_pct      = drive_pct_of(img[POS_DRIVE +: 2]);
      cfg.timer_irq_off  = img[POS_TIMER];
      bad = img[POS_ZERO]
          | (img[POS_MULT +: 3] == MULT_RSV_CODE)
          | (img[POS_RATE +: 4] > RATE_MAX_CODE);
   end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
   import boot_cfg_pkg::*;
#(
   parameter int unsigned DIV_RATIO   = 256,
   parameter int unsigned START_DELAY = 256,
   parameter int unsigned STREAM_BITS = 256,
   parameter int unsigned HOLD_CYCLES = 65537,
   parameter bit          FULL_IMAGE  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       warm_rst,
   input  logic       serial_in,
   output logic       mode_clk,
   output logic       cfg_done,
   output logic       cfg_err,
   output logic       cpu_release,
   output logic [2:0] mult_code,
   output logic [3:0] mult_factor,
   output logic       big_endian,
   output logic       bus_32bit,
   output logic [1:0] single_wr_mode,
   output logic [3:0] blk_wr_rate,
   output logic [2:0] wr_data_delay,
   output logic [1:0] drive_code,
   output logic [6:0] drive_pct,
   output logic       timer_irq_off
);

   if (DIV_RATIO < 4 || (DIV_RATIO % 2) != 0) begin : g_bad_div
      $error("DIV_RATIO must be even and at least 4");
   end
   if (STREAM_BITS < FIELD_W) begin : g_bad_len
      $error("STREAM_BITS must cover all decoded positions");
   end
   if (START_DELAY < 1 || HOLD_CYCLES < 1) begin : g_bad_cnt
      $error("START_DELAY and HOLD_CYCLES must be nonzero");
   end

   logic               sample_stb, last_stb, capture_clr;
   logic [FIELD_W-1:0] img_next;
   boot_cfg_t          cfg_dec, cfg_q;
   logic               bad_dec, err_q, done_q;

   boot_seq_ctrl #(
      .DIV_RATIO  (DIV_RATIO),
      .START_DELAY(START_DELAY),
      .STREAM_BITS(STREAM_BITS),
      .HOLD_CYCLES(HOLD_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_good   (pwr_good),
      .warm_rst   (warm_rst),
      .mode_clk   (mode_clk),
      .sample_stb (sample_stb),
      .last_stb   (last_stb),
      .capture_clr(capture_clr),
      .cpu_release(cpu_release)
   );

   boot_capture #(
      .STREAM_BITS(STREAM_BITS),
      .FULL_IMAGE (FULL_IMAGE)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (capture_clr),
      .stb     (sample_stb),
      .din     (serial_in),
      .img_next(img_next)
   );

   boot_field_decode u_dec (
      .img(img_next),
      .cfg(cfg_dec),
      .bad(bad_dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (!pwr_good) begin
         cfg_q  <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (last_stb) begin
         cfg_q  <= cfg_dec;
         err_q  <= bad_dec;
         done_q <= 1'b1;
      end
   end

   assign cfg_done       = done_q;
   assign cfg_err        = err_q;
   assign mult_code      = cfg_q.mult_code;
   assign mult_factor    = cfg_q.mult_factor;
   assign big_endian     = cfg_q.big_endian;
   assign bus_32bit      = cfg_q.bus_32bit;
   assign single_wr_mode = cfg_q.single_wr_mode;
   assign blk_wr_rate    = cfg_q.blk_wr_rate;
   assign wr_data_delay  = cfg_q.wr_data_delay;
   assign drive_code     = cfg_q.drive_code;
   assign drive_pct      = cfg_q.drive_pct;
   assign timer_irq_off  = cfg_q.timer_irq_off;

endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pwr_good,
   input logic        warm_rst,
   input logic        serial_in,
   input logic        mode_clk,
   input logic        cfg_done,
   input logic        cfg_err,
   input logic        cpu_release,
   input logic [27:0] cfg_bits
);

   // R10: latched fields are frozen while loaded and powered
   p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && pwr_good) |=> $stable(cfg_bits));

   // R11: release only after a completed load
   p_release_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_release |-> cfg_done);

   // R12: warm reset withholds release from the next edge
   p_warm_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> !cpu_release);

   // R3: completion coincides with the final falling mode clock edge
   p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_done) |-> $fell(mode_clk));

   // R3: mode clock is quiet once loaded
   p_mclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> !mode_clk);

   // R8: error only reported with a completed load
   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> cfg_done);

   // R13: power loss clears state at the edge that sees it
   p_pg_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!cfg_done && !cpu_release && !mode_clk && !cfg_err));

   // R4: input setup window before each sampling edge
   p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_clk) |-> (serial_in == $past(serial_in)) && ($past(serial_in) == $past(serial_in, 2)));

endmodule

bind boot_mode_loader boot_mode_loader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_good   (pwr_good),
   .warm_rst   (warm_rst),
   .serial_in  (serial_in),
   .mode_clk   (mode_clk),
   .cfg_done   (cfg_done),
   .cfg_err    (cfg_err),
   .cpu_release(cpu_release),
   .cfg_bits   ({mult_code, mult_factor, big_endian, bus_32bit, single_wr_mode,
                 blk_wr_rate, wr_data_delay, drive_code, drive_pct, timer_irq_off})
);

// File: tb/boot_mode_loader_bench.sv
`timescale 1ns/1ps
module boot_mode_loader_bench;

   localparam int DIV   = 8;
   localparam int START = 16;
   localparam int BITS  = 256;
   localparam int HOLD  = 64;
   localparam int WD_CYCLES = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic warm_rst = 1'b0;
   logic serial_in = 1'b0;
   logic mode_clk, cfg_done, cfg_err, cpu_release;
   logic [2:0] mult_code;
   logic [3:0] mult_factor;
   logic big_endian, bus_32bit, timer_irq_off;
   logic [1:0] single_wr_mode, drive_code;
   logic [3:0] blk_wr_rate;
   logic [2:0] wr_data_delay;
   logic [6:0] drive_pct;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int mc_rises = 0;
   int per_bad = 0;
   int last_rise = 0;
   logic [17:0] exp_q[$];

   always #2.5 clk = ~clk;

   boot_mode_loader #(
      .DIV_RATIO(DIV), .START_DELAY(START), .STREAM_BITS(BITS), .HOLD_CYCLES(HOLD)
   ) u_boot_mode_loader (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .warm_rst(warm_rst),
      .serial_in(serial_in), .mode_clk(mode_clk), .cfg_done(cfg_done),
      .cfg_err(cfg_err), .cpu_release(cpu_release), .mult_code(mult_code),
      .mult_factor(mult_factor), .big_endian(big_endian), .bus_32bit(bus_32bit),
      .single_wr_mode(single_wr_mode), .blk_wr_rate(blk_wr_rate),
      .wr_data_delay(wr_data_delay), .drive_code(drive_code),
      .drive_pct(drive_pct), .timer_irq_off(timer_irq_off)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [17:0] mk(input logic b0, input logic [3:0] rate,
      input logic [2:0] mult, input logic big, input logic [1:0] wr, input logic toff,
      input logic b32, input logic [1:0] drv, input logic [2:0] dly);
      return {dly, drv, b32, toff, wr, big, mult, rate, b0};
   endfunction

   function automatic int exp_err(input logic [17:0] img);
      return int'(img[0] || (img[7:5] == 3'd7) || (img[4:1] > 4'd8));
   endfunction

   function automatic int exp_factor(input logic [2:0] m);
      return (m == 3'd7) ? 0 : int'(m) + 2;
   endfunction

   function automatic int exp_pct(input logic [1:0] d);
      case (d)
         2'b10: return 100;
         2'b11: return 83;
         2'b00: return 67;
         default: return 50;
      endcase
   endfunction

   always @(posedge clk) cyc++;

   always @(posedge mode_clk) begin
      if (mc_rises > 0 && (cyc - last_rise) != DIV) per_bad++;
      last_rise = cyc;
      mc_rises++;
   end

   // Monitor: pops the expected image when a load completes
   always begin
      logic [17:0] e;
      int hc;
      @(posedge cfg_done);
      @(negedge clk);
      if (exp_q.size() == 0) begin
         chk(1'b0, "R10 unexpected completion", 1, 0);
      end else begin
         e = exp_q.pop_front();
         chk(mult_code == e[7:5], "R5 R4 multiplier code", int'(mult_code), int'(e[7:5]));
         chk(int'(mult_factor) == exp_factor(e[7:5]), "R6 factor", int'(mult_factor), exp_factor(e[7:5]));
         chk(big_endian == e[8], "R5 byte order", int'(big_endian), int'(e[8]));
         chk(single_wr_mode == e[10:9], "R5 write mode", int'(single_wr_mode), int'(e[10:9]));
         chk(timer_irq_off == e[11], "R5 timer", int'(timer_irq_off), int'(e[11]));
         chk(bus_32bit == e[12], "R5 bus width", int'(bus_32bit), int'(e[12]));
         chk(drive_code == e[14:13], "R5 drive code", int'(drive_code), int'(e[14:13]));
         chk(int'(drive_pct) == exp_pct(e[14:13]), "R7 drive pct", int'(drive_pct), exp_pct(e[14:13]));
         chk(blk_wr_rate == e[4:1], "R5 R4 data pattern", int'(blk_wr_rate), int'(e[4:1]));
         chk(wr_data_delay == e[17:15], "R5 delay", int'(wr_data_delay), int'(e[17:15]));
         chk(int'(cfg_err) == exp_err(e), "R8 error", int'(cfg_err), exp_err(e));
         hc = 0;
         while (!cpu_release && hc < HOLD + 10) begin
            hc++;
            @(negedge clk);
         end
         chk(hc == HOLD, "R11 hold length", hc, HOLD);
      end
   end

   // Driver: pushes the expected image and plays the stream
   task automatic run_load(input logic [17:0] img, input logic rsv);
      int n;
      exp_q.push_back(img);
      mc_rises = 0;
      per_bad = 0;
      @(negedge clk);
      pwr_good = 1'b1;
      serial_in = 1'b0;
      n = 0;
      while (!mode_clk && n < 1000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk(n == START + DIV / 2 + 1, "R2 start delay", n, START + DIV / 2 + 1);
      serial_in = img[0];
      for (int k = 1; k < BITS; k++) begin
         @(posedge mode_clk);
         #1;
         serial_in = (k < 18) ? img[k] : rsv;
      end
      wait (cpu_release === 1'b1);
      @(negedge clk);
      chk(mc_rises == BITS, "R3 rising edge count", mc_rises, BITS);
      chk(per_bad == 0, "R3 period", per_bad, 0);
      if (rsv) chk(int'(cfg_err) == exp_err(img), "R9 reserved ones ignored", int'(cfg_err), exp_err(img));
   endtask

   task automatic drop_power();
      @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk);
      chk(!cfg_done && !cpu_release && !cfg_err && !mode_clk, "R13 cleared",
          int'({cfg_done, cpu_release, cfg_err, mode_clk}), 0);
      chk(mult_code == 3'd0 && drive_pct == 7'd0, "R13 fields cleared",
          int'({mult_code, drive_pct}), 0);
   endtask

   initial begin : watchdog
      #(WD_CYCLES * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [17:0] img1;
      bit hi_seen;
      repeat (3) @(negedge clk);
      chk({mode_clk, cfg_done, cfg_err, cpu_release} == 4'b0, "R1 in reset",
          int'({mode_clk, cfg_done, cfg_err, cpu_release}), 0);
      rst_n = 1'b1;
      hi_seen = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (mode_clk || cfg_done || cpu_release) hi_seen = 1'b1;
      end
      chk(!hi_seen, "R1 idle without power good", int'(hi_seen), 0);
      chk(mult_factor == 4'd0 && drive_pct == 7'd0, "R1 fields zero", int'(drive_pct), 0);

      img1 = mk(1'b0, 4'd3, 3'd2, 1'b1, 2'b10, 1'b0, 1'b1, 2'b10, 3'd5);
      run_load(img1, 1'b0);

      // R12: warm reset keeps fields and does not reload
      @(negedge clk);
      warm_rst = 1'b1;
      @(negedge clk);
      chk(!cpu_release, "R12 release withheld", int'(cpu_release), 0);
      mc_rises = 0;
      repeat (2 * DIV) @(negedge clk);
      chk(!cpu_release && cfg_done, "R12 done kept, release low", int'({cpu_release, cfg_done}), 1);
      warm_rst = 1'b0;
      @(negedge clk);
      chk(cpu_release, "R12 release returns", int'(cpu_release), 1);
      chk(mc_rises == 0, "R12 no reload", mc_rises, 0);
      chk(wr_data_delay == 3'd5 && blk_wr_rate == 4'd3 && mult_code == 3'd2,
          "R12 fields kept", int'({wr_data_delay, blk_wr_rate, mult_code}),
          int'({3'd5, 4'd3, 3'd2}));

      drop_power();
      run_load(mk(1'b0, 4'd8, 3'd6, 1'b0, 2'b11, 1'b1, 1'b0, 2'b11, 3'd7), 1'b1);
      drop_power();
      run_load(mk(1'b0, 4'd0, 3'd7, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 3'd0), 1'b0);
      drop_power();
      run_load(mk(1'b1, 4'd5, 3'd0, 1'b0, 2'b01, 1'b1, 1'b1, 2'b01, 3'd3), 1'b1);
      drop_power();
      run_load(mk(1'b0, 4'd9, 3'd4, 1'b1, 2'b10, 1'b0, 1'b0, 2'b10, 3'd1), 1'b0);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R10 all loads completed", exp_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule